// File: doc/BRIEF.md
# Filtered External Interrupt Edge Detector

This block watches sixteen maskable interrupt request pins and two non-maskable interrupt pins. It produces a one-clock event pulse on a per-pin output whenever an enabled falling edge is recognised. Every pin is first brought into the system clock domain by a two-stage synchroniser. Pins are high when idle.

The sixteen maskable pins then pass through a digital filter. The filter length is programmable and shared by all sixteen pins. A new level must persist for 2^DFL consecutive system clocks before it is accepted, so shorter pulses are thrown away. The non-maskable pins are synchronised but not filtered. Their enable bits can be written only once after reset.

Software reaches the block through a small register port. It has single-cycle write and read strobes, a 2-bit word address and 32-bit data. Word 0 holds the edge enables and word 1 holds the filter length. Read data is registered. There is no streaming data path, so every pin is a plain level signal with no valid/ready handshake and no back-pressure.

Top module: `xirq_edge_unit`

## Requirements
- R1: After reset, every enable bit and the filter length are 0, words 0 and 1 read as 0, and no event output is high.
- R2: In word 0, bit n (n = 0..15) is the falling-edge enable of maskable pin n. It is written by every write to word 0 and reads back as written.
- R3: In word 0, bit 31 enables non-maskable pin 0 and bit 30 enables non-maskable pin 1. These two bits take their value from the first write to word 0 after reset, whatever that value is. All later writes leave them unchanged until the next reset.
- R4: Word 1 bits [3:0] hold the filter length DFL, and bits [31:4] read as 0. Words 2 and 3 read as 0, and writes to them change nothing.
- R5: A maskable pin's filtered level changes only after the synchronised input has held the new level for 2^DFL consecutive clocks. A low pulse shorter than that produces no event.
- R6: When a maskable pin changes from high to low before a rising clock edge, its event output goes high after the (2 + 2^DFL)-th rising edge that follows.
- R7: Each accepted falling edge gives an event pulse exactly one clock wide. Accepted rising edges give no event.
- R8: A disabled pin gives no event, but its filter still tracks the input. Enabling a pin that is already low gives no event until the pin next falls.
- R9: A non-maskable pin with its enable set raises its event output after the third rising edge following a high-to-low change. The pin is not filtered. With its enable clear it gives no event.
- R10: If an enable write falls on the same clock edge as an accepted falling edge, the event uses the enable value held before that write.
- R11: rd_data loads the addressed word on each rising edge where rd_en is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| rd_en | input | 1 | Single-cycle register read strobe |
| addr | input | 2 | Word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_pin | input | 16 | Maskable interrupt pins, idle high |
| nmi_pin | input | 2 | Non-maskable interrupt pins, idle high |
| irq_evt | output | 16 | One-clock event pulse per maskable pin |
| nmi_evt | output | 2 | One-clock event pulse per non-maskable pin |

## Verification
A register write that changes an enable can fall on the same clock edge as the filter accepting a falling edge on that pin. The bench uses DFL 0 so that acceptance comes on the third rising edge after the pin drops. It then raises the write strobe so that the write is captured on that same edge, once to enable a disabled pin and once to disable an enabled pin. The event count on that pin is judged against the old enable: no pulse in the first case, exactly one in the second.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int N_IRQ     = 16;
  localparam int N_NMI     = 2;
  localparam int DFL_W     = 4;
  localparam int CNT_W     = 1 << DFL_W;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 32;
  localparam logic [ADDR_W-1:0] ADDR_EDGE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FILT = 2'd1;

  // Word 0 layout: maskable enables low, non-maskable enables from the top down.
  function automatic logic [DATA_W-1:0] edge_word(input logic [N_IRQ-1:0] irq,
                                                  input logic [N_NMI-1:0] nmi);
    logic [DATA_W-1:0] w;
    w = '0;
    w[N_IRQ-1:0] = irq;
    for (int n = 0; n < N_NMI; n++) w[DATA_W-1-n] = nmi[n];
    return w;
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int   W    = 1,
  parameter logic IDLE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= {W{IDLE}};
      s2_q <= {W{IDLE}};
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/xirq_filter.sv
module xirq_filter #(
  parameter int   DW   = 4,
  parameter int   CW   = 16,
  parameter logic IDLE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [DW-1:0] dfl,
  output logic          fall_acc
);
  logic [CW:0]   period, cnt_nx;
  logic [CW-1:0] cnt_q;
  logic          lvl_q, differ, accept;

  assign period = (CW+1)'(1) << dfl;
  assign differ = din != lvl_q;
  assign cnt_nx = {1'b0, cnt_q} + (CW+1)'(1);
  // >= keeps a count that outgrew a shortened period from stalling
  assign accept = differ && (cnt_nx >= period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= IDLE;
      cnt_q <= '0;
    end else begin
      if (!differ || accept) cnt_q <= '0;
      else                   cnt_q <= cnt_nx[CW-1:0];
      if (accept) lvl_q <= din;
    end
  end

  assign fall_acc = accept & ~din;

  // R5: with a period above one clock, the new level was already present two cycles back
  a_r5_level_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(lvl_q) && $past(dfl) != '0) |-> ($past(din, 2) == lvl_q));
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [N_IRQ-1:0]  irq_en,
  output logic [N_NMI-1:0]  nmi_en,
  output logic [DFL_W-1:0]  dfl
);
  logic [N_IRQ-1:0]  irq_en_q;
  logic [N_NMI-1:0]  nmi_en_q;
  logic [DFL_W-1:0]  dfl_q;
  logic              locked_q;
  logic [DATA_W-1:0] rd_mux, rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= '0;
      nmi_en_q <= '0;
      dfl_q    <= '0;
      locked_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == ADDR_EDGE) begin
        irq_en_q <= wr_data[N_IRQ-1:0];
        locked_q <= 1'b1;
        if (!locked_q)
          for (int n = 0; n < N_NMI; n++) nmi_en_q[n] <= wr_data[DATA_W-1-n];
      end else if (addr == ADDR_FILT) begin
        dfl_q <= wr_data[DFL_W-1:0];
      end
    end
  end

  always_comb begin
    case (addr)
      ADDR_EDGE: rd_mux = edge_word(irq_en_q, nmi_en_q);
      ADDR_FILT: rd_mux = {{(DATA_W-DFL_W){1'b0}}, dfl_q};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign rd_data = rd_q;
  assign irq_en  = irq_en_q;
  assign nmi_en  = nmi_en_q;
  assign dfl     = dfl_q;

  a_r3_nmi_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_en && addr == ADDR_EDGE) |=> $stable(nmi_en_q));
  a_r4_filt_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_FILT) |=> (rd_data[DATA_W-1:DFL_W] == '0));
  a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/xirq_edge_unit.sv
module xirq_edge_unit
  import xirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [N_IRQ-1:0]  irq_pin,
  input  logic [N_NMI-1:0]  nmi_pin,
  output logic [N_IRQ-1:0]  irq_evt,
  output logic [N_NMI-1:0]  nmi_evt
);
  logic [N_IRQ-1:0] irq_s, irq_fall, irq_en, irq_evt_q;
  logic [N_NMI-1:0] nmi_s, nmi_prev_q, nmi_en, nmi_evt_q;
  logic [DFL_W-1:0] dfl;

  xirq_regs u_regs (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wr_data, .rd_data,
    .irq_en(irq_en), .nmi_en(nmi_en), .dfl(dfl)
  );

  xirq_sync #(.W(N_IRQ), .IDLE(1'b1)) u_irq_sync (
    .clk, .rst_n, .d(irq_pin), .q(irq_s)
  );
  xirq_sync #(.W(N_NMI), .IDLE(1'b1)) u_nmi_sync (
    .clk, .rst_n, .d(nmi_pin), .q(nmi_s)
  );

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    xirq_filter #(.DW(DFL_W), .CW(CNT_W), .IDLE(1'b1)) u_flt (
      .clk, .rst_n, .din(irq_s[g]), .dfl(dfl), .fall_acc(irq_fall[g])
    );

    a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      irq_evt_q[g] |=> !irq_evt_q[g]);
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_evt_q[g] |-> $past(irq_en[g]));
  end

  for (genvar k = 0; k < N_NMI; k++) begin : g_nmi
    a_r9_nmi_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_evt_q[k] |-> ($past(nmi_s[k], 2) && !$past(nmi_s[k]) && $past(nmi_en[k])));
  end

  // Enables are sampled before any same-edge write lands (R10).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_evt_q  <= '0;
      nmi_evt_q  <= '0;
      nmi_prev_q <= '1;
    end else begin
      irq_evt_q  <= irq_fall & irq_en;
      nmi_evt_q  <= nmi_prev_q & ~nmi_s & nmi_en;
      nmi_prev_q <= nmi_s;
    end
  end

  assign irq_evt = irq_evt_q;
  assign nmi_evt = nmi_evt_q;
endmodule

// File: tb/xirq_edge_unit_bench.sv
`timescale 1ns/1ps
module xirq_edge_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [15:0] irq_pin = '1;
  logic [1:0]  nmi_pin = '1;
  logic [15:0] irq_evt;
  logic [1:0]  nmi_evt;

  int n_tests = 0, n_fail = 0;
  int evt_cnt [16];
  int nmi_cnt [2];
  int evt_all = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xirq_edge_unit u_xirq_edge_unit (
    .clk, .rst_n, .wr_en, .rd_en, .addr, .wr_data, .rd_data,
    .irq_pin, .nmi_pin, .irq_evt, .nmi_evt
  );

  initial begin
    for (int i = 0; i < 16; i++) evt_cnt[i] = 0;
    for (int i = 0; i < 2; i++) nmi_cnt[i] = 0;
  end

  always @(negedge clk) begin
    for (int i = 0; i < 16; i++) if (irq_evt[i]) begin evt_cnt[i]++; evt_all++; end
    for (int i = 0; i < 2; i++) if (nmi_evt[i]) nmi_cnt[i]++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_pin = '1; nmi_pin = '1; wr_en = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  // {dfl[3:0], pin[3:0], low_len[7:0], enable, expected events}
  localparam int NV = 9;
  localparam logic [17:0] VEC [NV] = '{
    {4'd0, 4'd0,  8'd1,  1'b1, 1'b1},
    {4'd0, 4'd15, 8'd1,  1'b0, 1'b0},
    {4'd2, 4'd5,  8'd3,  1'b1, 1'b0},
    {4'd2, 4'd5,  8'd4,  1'b1, 1'b1},
    {4'd3, 4'd9,  8'd7,  1'b1, 1'b0},
    {4'd3, 4'd9,  8'd8,  1'b1, 1'b1},
    {4'd1, 4'd15, 8'd20, 1'b1, 1'b1},
    {4'd4, 4'd12, 8'd15, 1'b1, 1'b0},
    {4'd4, 4'd12, 8'd16, 1'b1, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int bp, ba, b0, b1;
    do_reset();

    // R1: reset state
    check("R1 evt", {14'd0, irq_evt, nmi_evt}, 32'd0);
    rd(2'd0, d); check("R1 word0", d, 32'd0);
    rd(2'd1, d); check("R1 word1", d, 32'd0);

    // Vector walk: R5 filter length, R7 single pulse, R8 disabled pin, R2 bit map
    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      int dl, pn, ln;
      v = VEC[i];
      dl = int'(v[17:14]); pn = int'(v[13:10]); ln = int'(v[9:2]);
      wr(2'd1, 32'(dl));
      wr(2'd0, v[1] ? (32'd1 << pn) : 32'd0);
      repeat (4) @(negedge clk);
      bp = evt_cnt[pn]; ba = evt_all;
      irq_pin[pn] = 1'b0;
      repeat (ln) @(negedge clk);
      irq_pin[pn] = 1'b1;
      repeat (ln + (1 << dl) + 8) @(negedge clk);
      check($sformatf("R5 R7 R8 vec%0d pin", i), 32'(evt_cnt[pn] - bp), 32'(v[0]));
      check($sformatf("R7 vec%0d all", i), 32'(evt_all - ba), 32'(v[0]));
    end

    // R2: read back of maskable enables
    wr(2'd0, 32'h0000_A5C3);
    rd(2'd0, d); check("R2 readback", d, 32'h0000_A5C3);

    // R6: latency with DFL=0 and DFL=2, R7 width
    wr(2'd1, 32'd0); wr(2'd0, 32'h0000_0004);
    repeat (3) @(negedge clk);
    irq_pin[2] = 1'b0;
    repeat (2) @(posedge clk);
    #1 check("R6 dfl0 early", 32'(irq_evt[2]), 32'd0);
    @(posedge clk); #1 check("R6 dfl0 edge3", 32'(irq_evt[2]), 32'd1);
    @(posedge clk); #1 check("R7 dfl0 width", 32'(irq_evt[2]), 32'd0);
    @(negedge clk); irq_pin[2] = 1'b1;
    wr(2'd1, 32'd2);
    repeat (8) @(negedge clk);
    irq_pin[2] = 1'b0;
    repeat (5) @(posedge clk);
    #1 check("R6 dfl2 edge5", 32'(irq_evt[2]), 32'd0);
    @(posedge clk); #1 check("R6 dfl2 edge6", 32'(irq_evt[2]), 32'd1);
    @(posedge clk); #1 check("R7 dfl2 width", 32'(irq_evt[2]), 32'd0);
    @(negedge clk); irq_pin[2] = 1'b1;
    repeat (10) @(negedge clk);

    // R8: disabled pin still tracked by its filter
    wr(2'd1, 32'd0); wr(2'd0, 32'd0);
    bp = evt_cnt[7];
    irq_pin[7] = 1'b0; repeat (10) @(negedge clk);
    check("R8 disabled low", 32'(evt_cnt[7] - bp), 32'd0);
    wr(2'd0, 32'h0000_0080); repeat (10) @(negedge clk);
    check("R8 enable while low", 32'(evt_cnt[7] - bp), 32'd0);
    irq_pin[7] = 1'b1; repeat (10) @(negedge clk);
    irq_pin[7] = 1'b0; repeat (10) @(negedge clk);
    check("R8 next fall", 32'(evt_cnt[7] - bp), 32'd1);
    irq_pin[7] = 1'b1; repeat (10) @(negedge clk);

    // R10: enable write on the acceptance edge
    wr(2'd0, 32'd0); repeat (4) @(negedge clk);
    bp = evt_cnt[4];
    irq_pin[4] = 1'b0;
    repeat (2) @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wr_data = 32'h0000_0010;
    @(negedge clk); wr_en = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 enable same edge", 32'(evt_cnt[4] - bp), 32'd0);
    irq_pin[4] = 1'b1; repeat (10) @(negedge clk);
    bp = evt_cnt[4];
    irq_pin[4] = 1'b0;
    repeat (2) @(negedge clk);
    wr_en = 1'b1; addr = 2'd0; wr_data = 32'd0;
    @(negedge clk); wr_en = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 disable same edge", 32'(evt_cnt[4] - bp), 32'd1);
    irq_pin[4] = 1'b1; repeat (10) @(negedge clk);

    // R3 and R9: write-once non-maskable enables
    do_reset();
    wr(2'd0, 32'h8000_0000);
    rd(2'd0, d); check("R3 first write", d, 32'h8000_0000);
    wr(2'd0, 32'h4000_FFFF);
    rd(2'd0, d); check("R3 second write ignored", d, 32'h8000_FFFF);
    b0 = nmi_cnt[0]; b1 = nmi_cnt[1];
    @(negedge clk); nmi_pin[0] = 1'b0;
    repeat (2) @(posedge clk);
    #1 check("R9 nmi early", 32'(nmi_evt[0]), 32'd0);
    @(posedge clk); #1 check("R9 nmi edge3", 32'(nmi_evt[0]), 32'd1);
    @(negedge clk); nmi_pin[1] = 1'b0;
    repeat (8) @(negedge clk);
    check("R9 nmi0 count", 32'(nmi_cnt[0] - b0), 32'd1);
    check("R9 nmi1 disabled", 32'(nmi_cnt[1] - b1), 32'd0);
    nmi_pin = '1; repeat (4) @(negedge clk);

    // R3 with a zero first write, R4 field and unmapped words, R11 hold
    do_reset();
    wr(2'd0, 32'd0);
    wr(2'd0, 32'hC000_0000);
    rd(2'd0, d); check("R3 zero first write locks", d, 32'd0);
    wr(2'd2, 32'hFFFF_FFFF); wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, d); check("R4 word2", d, 32'd0);
    rd(2'd3, d); check("R4 word3", d, 32'd0);
    rd(2'd1, d); check("R4 word1 untouched", d, 32'd0);
    rd(2'd0, d); check("R4 word0 untouched", d, 32'd0);
    wr(2'd1, 32'hFFFF_FFF7);
    rd(2'd1, d); check("R4 dfl field", d, 32'h0000_0007);
    wr(2'd1, 32'd3); repeat (3) @(negedge clk);
    check("R11 rd_data holds", rd_data, 32'h0000_0007);
    rd(2'd1, d); check("R11 rd_data reloads", d, 32'h0000_0003);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule